// File: doc/BRIEF.md
# Warp Issue Scheduler with Outstanding-Load Scoreboard

This block picks at most one warp per clock from a pool of resident warps and hands its index to the execution pipeline. It always schedules whole warps and never single threads. Each warp has a small counter of memory loads it has sent and not yet received back. When a warp is chosen and its next instruction is a load, its counter goes up at the clock edge, and the warp is set aside. In the same cycle the other ready warps keep competing, so one slow memory access does not stall issue.

A load return pulse for a warp lowers that warp's counter in the cycle it arrives. In that cycle the warp is held back, and it becomes eligible again on the following cycle. Ready warps are picked in round-robin order, starting just after the warp that issued last. With enough resident warps to cover the memory latency, a warp is issued on every cycle. With too few, idle cycles appear.

Top module: `wsched_top`

## Requirements
- R1: While reset is held, every outstanding-load counter is cleared, and with no warp resident issueValid is 0. After reset the round-robin pointer starts so that, with all warps resident and ready, warp 0 issues first.
- R2: A warp is eligible in a cycle only when its warpValid bit is 1, its outstanding-load counter is 0, and its loadReturn bit is 0 in that cycle. Only an eligible warp is ever issued.
- R3: A warp issued while its nextIsLoad bit is 1 is ineligible from the next cycle onward. It stays ineligible up to and including the cycle its loadReturn pulse arrives, and is eligible again in the following cycle.
- R4: A warp issued while its nextIsLoad bit is 0 stays eligible in the next cycle, provided it is still resident and sees no return.
- R5: Among eligible warps, the issued warp is the first one found scanning upward, with wrap, from the index one above the last issued warp.
- R6: When no warp is eligible, issueValid is 0 and issueWarp is 0. Otherwise issueValid is 1.
- R7: A loadReturn pulse for a warp whose counter is already 0 is ignored and does not wrap the counter. The warp is eligible again in the next cycle, and its next load parks it only until that load's own return.
- R8: An eligible warp waits at most NumWarps-1 consecutive eligible cycles before it is issued (no starvation).
- R9: When every warp is resident and issues only loads with a fixed latency of L cycles, issue reaches one warp per cycle once NumWarps ≥ L+1. With fewer resident warps, idle cycles occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| warpValid | input | NumWarps | Warp is resident in the pool |
| nextIsLoad | input | NumWarps | Warp's next instruction is a memory load |
| loadReturn | input | NumWarps | Data of one outstanding load of the warp returns this cycle |
| issueValid | output | 1 | A warp is issued this cycle |
| issueWarp | output | $clog2(NumWarps) | Index of the issued warp, 0 when none |

## Verification
The scheduler is tried under several kinds of input:
- Pure compute traffic with all warps resident. This separates the round-robin order from a fixed-priority order.
- Sparse and changing residency masks. These show whether the scan skips absent warps and wraps correctly.
- A single load from one warp among many ready ones. This exposes off-by-one errors in when a warp is parked and when it is released.
- A stray return to an idle warp. This separates an ignored pulse from a counter that wraps.
- All-load traffic with a fixed latency, once with sixteen resident warps and once with four. These two runs tell full utilisation apart from latency-limited bubbles.
- A long run with random residency, load mix and latencies of 200 to 600 cycles. Every cycle is compared against an arithmetic model, and the longest wait of any eligible warp is measured.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int MaxIdxW = 8;

  typedef struct packed {
    logic               issue;
    logic               loadIssue;
    logic [MaxIdxW-1:0] idx;
  } issue_strobe_t;
endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NumWarps = 16,
  localparam int IdxW = $clog2(NumWarps)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumWarps-1:0] eligible,
  input  logic [NumWarps-1:0] nextIsLoad,
  output issue_strobe_t       strobe
);
  logic [IdxW-1:0] lastPtr;
  logic [IdxW-1:0] pickIdx;
  logic            pickFound;

  // Round-robin scan beginning one past the last issued warp
  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    for (int k = 0; k < NumWarps; k++) begin
      int c;
      c = int'(lastPtr) + 1 + k;
      if (c >= NumWarps) c = c - NumWarps;
      if (!pickFound && eligible[c]) begin
        pickFound = 1'b1;
        pickIdx   = IdxW'(c);
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.issue     = pickFound;
    strobe.loadIssue = pickFound && nextIsLoad[pickIdx];
    strobe.idx       = MaxIdxW'(pickIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastPtr <= IdxW'(NumWarps - 1);
    else if (pickFound) lastPtr <= pickIdx;
  end

  // R2: the issued warp is one the datapath marked eligible
  a_r2_pick_eligible: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> eligible[strobe.idx[IdxW-1:0]]);

  // R6: no eligible warp means no issue
  a_r6_idle_when_none: assert property (@(posedge clk) disable iff (!rstN)
    (eligible == '0) |-> (!strobe.issue && strobe.idx == '0));
endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
#(
  parameter int NumWarps = 16,
  parameter int CntMax   = 4,
  localparam int IdxW = $clog2(NumWarps),
  localparam int CntW = $clog2(CntMax + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumWarps-1:0] warpValid,
  input  logic [NumWarps-1:0] loadReturn,
  input  issue_strobe_t       strobe,
  output logic [NumWarps-1:0] eligible
);
  for (genvar i = 0; i < NumWarps; i++) begin : g_warp
    logic [CntW-1:0] pendCnt;
    logic            incHit;
    logic            decHit;

    assign incHit = strobe.loadIssue && (strobe.idx[IdxW-1:0] == IdxW'(i))
                    && (pendCnt != CntW'(CntMax));
    assign decHit = loadReturn[i] && (pendCnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN) pendCnt <= '0;
      else if (incHit && !decHit) pendCnt <= pendCnt + 1'b1;
      else if (decHit && !incHit) pendCnt <= pendCnt - 1'b1;
    end

    assign eligible[i] = warpValid[i] && (pendCnt == '0) && !loadReturn[i];

    // R3: a load issue parks the warp from the next cycle
    a_r3_park_after_load: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.loadIssue && strobe.idx[IdxW-1:0] == IdxW'(i)) |=> (pendCnt != '0));

    // R4: a non-load issue leaves the counter empty
    a_r4_nonload_free: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.issue && !strobe.loadIssue && strobe.idx[IdxW-1:0] == IdxW'(i))
      |=> (pendCnt == '0));

    // R7: a return with nothing outstanding does not wrap the counter
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
      (pendCnt == '0 && loadReturn[i]) |=> (pendCnt == '0));
  end
endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NumWarps = 16,
  parameter int CntMax   = 4,
  localparam int IdxW = $clog2(NumWarps)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumWarps-1:0] warpValid,
  input  logic [NumWarps-1:0] nextIsLoad,
  input  logic [NumWarps-1:0] loadReturn,
  output logic                issueValid,
  output logic [IdxW-1:0]     issueWarp
);
  issue_strobe_t       strobe;
  logic [NumWarps-1:0] eligible;

  wsched_ctrl #(.NumWarps(NumWarps)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible),
    .nextIsLoad(nextIsLoad), .strobe(strobe)
  );

  wsched_dp #(.NumWarps(NumWarps), .CntMax(CntMax)) u_dp (
    .clk(clk), .rstN(rstN), .warpValid(warpValid),
    .loadReturn(loadReturn), .strobe(strobe), .eligible(eligible)
  );

  assign issueValid = strobe.issue;
  assign issueWarp  = strobe.idx[IdxW-1:0];
endmodule

// File: tb/wsched_top_test.sv
module wsched_top_test;
  localparam int NW = 16;
  localparam int IW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW-1:0] warpValid = '0;
  logic [NW-1:0] nextIsLoad = '0;
  logic [NW-1:0] loadReturn = '0;
  logic          issueValid;
  logic [IW-1:0] issueWarp;

  wsched_top #(.NumWarps(NW), .CntMax(4)) uut (
    .clk(clk), .rstN(rstN), .warpValid(warpValid), .nextIsLoad(nextIsLoad),
    .loadReturn(loadReturn), .issueValid(issueValid), .issueWarp(issueWarp)
  );

  always #10 clk = ~clk;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  // Bench model of scheduler state
  int  cyc = 0;
  int  mCnt[NW];
  int  retAt[NW];
  int  waitRun[NW];
  int  mLast = NW - 1;
  int  latMin = 5, latMax = 5;
  int  maxWait = 0;
  int  issuedCount = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic resetModel();
    for (int w = 0; w < NW; w++) begin
      mCnt[w] = 0; retAt[w] = -1; waitRun[w] = 0;
    end
    mLast = NW - 1;
  endtask

  // One cycle: drive, compare against model, advance model
  task automatic step(input logic [NW-1:0] vMask, input logic [NW-1:0] lMask,
                      input logic [NW-1:0] spur);
    logic [NW-1:0] ret;
    logic [NW-1:0] elig;
    int            pick;
    @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      ret[w] = (retAt[w] == cyc) || (spur[w] && mCnt[w] == 0);
    end
    warpValid  = vMask;
    nextIsLoad = lMask;
    loadReturn = ret;
    #5;
    for (int w = 0; w < NW; w++) elig[w] = vMask[w] && mCnt[w] == 0 && !ret[w];
    pick = -1;
    for (int k = 0; k < NW; k++) begin
      int c;
      c = (mLast + 1 + k) % NW;
      if (pick < 0 && elig[c]) pick = c;
    end
    // R2 R5 R6: issue matches eligibility and round-robin order
    check(issueValid == (pick >= 0), "R6", int'(issueValid), int'(pick >= 0));
    if (pick >= 0) check(int'(issueWarp) == pick, "R5", int'(issueWarp), pick);
    else check(issueWarp == '0, "R6", int'(issueWarp), 0);
    for (int w = 0; w < NW; w++) begin
      if (elig[w] && w != pick) begin
        waitRun[w]++;
        if (waitRun[w] > maxWait) maxWait = waitRun[w];
      end else waitRun[w] = 0;
    end
    if (pick >= 0) issuedCount++;
    @(posedge clk);
    #1;
    for (int w = 0; w < NW; w++) begin
      if (ret[w] && mCnt[w] > 0) begin
        mCnt[w]--; retAt[w] = -1;
      end
    end
    if (pick >= 0) begin
      mLast = pick;
      if (lMask[pick]) begin
        mCnt[pick]++;
        retAt[pick] = cyc + latMin + int'($urandom_range(latMax - latMin));
      end
    end
    cyc++;
  endtask

  initial begin
    logic [NW-1:0] vm;
    resetModel();
    // R1: reset state with nothing resident
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    check(issueValid == 1'b0, "R1", int'(issueValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 R5 R4: all resident, compute only; expect 0,1,2,...
    for (int t = 0; t < 40; t++) step('1, '0, '0);
    check(mLast == 39 % NW, "R5", mLast, 39 % NW);

    // R5: sparse and changing residency masks
    for (int t = 0; t < 600; t++) begin
      if (t % 50 == 0) vm = NW'($urandom());
      step(vm, '0, '0);
    end

    // R3: one load among ready warps, fixed latency 5
    latMin = 5; latMax = 5;
    for (int t = 0; t < 60; t++) step('1, NW'(t % 7 == 0), '0);
    // R3 directed: warp 2 alone
    for (int t = 0; t < 20; t++) step(NW'(4), NW'(4), '0);

    // R7: stray return on idle warp 3, then a real load
    step(NW'(8), '0, NW'(8));
    check(issueValid == 1'b0, "R7", int'(issueValid), 0);
    step(NW'(8), NW'(8), '0);
    check(mLast == 3, "R7", mLast, 3);
    for (int t = 0; t < 10; t++) step(NW'(8), '0, '0);
    check(issuedCount > 0, "R7", issuedCount, 1);

    // R9: full utilisation with 16 warps, all loads, latency 10
    latMin = 10; latMax = 10;
    for (int t = 0; t < 50; t++) step('1, '1, '0);
    issuedCount = 0;
    for (int t = 0; t < 500; t++) step('1, '1, '0);
    check(issuedCount == 500, "R9", issuedCount, 500);
    // R9: four warps cannot hide latency 10
    for (int t = 0; t < 30; t++) step(NW'(15), '1, '0);
    issuedCount = 0;
    for (int t = 0; t < 440; t++) step(NW'(15), '1, '0);
    check(issuedCount == 160, "R9", issuedCount, 160);

    // R8 R2 R3: random residency, 1-in-8 loads, latency 200..600
    latMin = 200; latMax = 600;
    maxWait = 0;
    for (int t = 0; t < 20000; t++) begin
      logic [NW-1:0] lm;
      if (t % 500 == 0) vm = NW'($urandom()) | NW'(1);
      for (int w = 0; w < NW; w++) lm[w] = ($urandom_range(7) == 0);
      step(vm, lm, '0);
    end
    check(maxWait <= NW - 1, "R8", maxWait, NW - 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule